// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a two-level translation structure from memory. A request carries the linear address. The block also takes the root register of the top-level directory and an enable bit that switches translation on. With translation on, the walker makes two reads in order on a simple memory read port. The first read fetches a directory entry. The base address held in that entry then selects the second-level table, and the second read fetches a table entry from it. The page base in the table entry is joined with the page offset to form the result. With translation off, the linear address comes back unchanged and no read is made.

Each entry carries a present flag. If that flag is clear at either level, the walk stops and the block reports a page fault instead of an address. The walker handles one request at a time and offers a ready level that is high only while it is idle. The surrounding logic uses it to hold back new requests until the current walk has finished.

Top module: `pg_walker`

## Requirements
- R1: After reset, `ready` is 1 and `done`, `fault` and `mem_rd` are all 0.
- R2: A request accepted with `map_en` = 0 gives `done` in the following cycle, with `phys` equal to the request's linear address and no memory read.
- R3: The first read of a walk uses address ({root[31:12], 12'h000} + 4 × lin[31:22]). The root and the linear address are taken in the cycle the request is accepted.
- R4: The second read uses address ({dir_entry[31:12], 12'h000} + 4 × lin[21:12]).
- R5: When both entries are present, `done` is 1 for exactly one cycle with `phys` = {table_entry[31:12], lin[11:0]}, and `ready` returns in the next cycle.
- R6: A directory entry whose bit 0 (present) is 0 ends the walk with a one-cycle `fault`, `phys` = 0 and no second read.
- R7: A table entry whose bit 0 is 0 ends the walk with a one-cycle `fault` and `phys` = 0.
- R8: `mem_rd` stays high and `mem_addr` stays stable from the start of a read until `mem_ack` is seen. The walk waits for as many cycles as memory takes.
- R9: A request is accepted only while `ready` is 1. A `req_valid` held high during a walk produces no extra result, and `ready` falls in the cycle after acceptance.
- R10: Each accepted request produces exactly one of `done` or `fault`, never both in the same cycle.
- R11: Bits 11:1 of directory and table entries have no effect on the read addresses or on `phys`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_lin | input | 32 | Linear address to translate |
| root_base | input | 32 | Directory root; bits 31:12 used |
| map_en | input | 1 | 1 = translate, 0 = pass-through |
| ready | output | 1 | Idle, request may be accepted |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_data | input | 32 | Memory read data |
| mem_ack | input | 1 | Read data valid |
| phys | output | 32 | Physical address, valid with `done` |
| done | output | 1 | Translation finished, one cycle |
| fault | output | 1 | Page fault, one cycle |

## Verification
Two functions can land in the same cycle. One is the completion of a walk, through `done` or `fault`. The other is the arrival of the next request, because a caller may hold `req_valid` high through the whole walk and into the completion cycle. The bench provokes this by holding `req_valid` with a different address until `ready` returns. The scoreboard then reports any result that was not predicted. It also checks that nothing is issued when the predicted read sequence is empty. Memory latencies of zero, one and three cycles place `mem_ack` on the first cycle of a read and on later cycles, so reads both with and without wait states are compared against the predicted addresses.

// File: rtl/pg_walker.sv
module pg_walker #(
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [DIR_W+TBL_W+OFF_W-1:0]   req_lin,
  input  logic [DIR_W+TBL_W+OFF_W-1:0]   root_base,
  input  logic                           map_en,
  output logic                           ready,
  output logic                           mem_rd,
  output logic [DIR_W+TBL_W+OFF_W-1:0]   mem_addr,
  input  logic [DIR_W+TBL_W+OFF_W-1:0]   mem_data,
  input  logic                           mem_ack,
  output logic [DIR_W+TBL_W+OFF_W-1:0]   phys,
  output logic                           done,
  output logic                           fault
);
  localparam int AW = DIR_W + TBL_W + OFF_W;
  localparam int BW = AW - OFF_W;

  typedef enum logic [2:0] {S_IDLE, S_DIR, S_TBL, S_DONE, S_FAULT} st_t;

  st_t            st;
  logic [AW-1:0]  lin_q;
  logic [BW-1:0]  root_q;
  logic [BW-1:0]  tbl_q;
  logic [BW-1:0]  pg_q;

  logic [AW-1:0]  dir_idx;
  logic [AW-1:0]  tbl_idx;
  logic [BW-1:0]  base_sel;
  logic [AW-1:0]  idx_sel;
  logic           present;

  assign dir_idx  = {{(AW-DIR_W){1'b0}}, lin_q[AW-1 -: DIR_W]};
  assign tbl_idx  = {{(AW-TBL_W){1'b0}}, lin_q[OFF_W +: TBL_W]};
  assign base_sel = (st == S_DIR) ? root_q : tbl_q;
  assign idx_sel  = (st == S_DIR) ? dir_idx : tbl_idx;
  assign present  = mem_data[0];

  assign ready    = (st == S_IDLE);
  assign mem_rd   = (st == S_DIR) || (st == S_TBL);
  assign mem_addr = mem_rd ? ({base_sel, {OFF_W{1'b0}}} + (idx_sel << 2)) : '0;
  assign done     = (st == S_DONE);
  assign fault    = (st == S_FAULT);
  assign phys     = done ? {pg_q, lin_q[OFF_W-1:0]} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      lin_q  <= '0;
      root_q <= '0;
      tbl_q  <= '0;
      pg_q   <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          lin_q  <= req_lin;
          root_q <= root_base[AW-1:OFF_W];
          if (map_en) begin
            st <= S_DIR;
          end else begin
            pg_q <= req_lin[AW-1:OFF_W];
            st   <= S_DONE;
          end
        end
        S_DIR: if (mem_ack) begin
          if (present) begin
            tbl_q <= mem_data[AW-1:OFF_W];
            st    <= S_TBL;
          end else begin
            st <= S_FAULT;
          end
        end
        S_TBL: if (mem_ack) begin
          if (present) begin
            pg_q <= mem_data[AW-1:OFF_W];
            st   <= S_DONE;
          end else begin
            st <= S_FAULT;
          end
        end
        S_DONE:  st <= S_IDLE;
        S_FAULT: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pg_walker_chk.sv
module pg_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_lin,
  input logic          map_en,
  input logic          ready,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic [AW-1:0] phys,
  input logic          done,
  input logic          fault
);
  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid && !map_en) |=> (done && phys == $past(req_lin) && !mem_rd));

  a_r5_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ready && !done));

  a_r6_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (phys == '0 && !mem_rd));

  a_r8_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> !ready);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!mem_rd && !done && !fault));
endmodule

bind pg_walker pg_walker_chk #(.AW(DIR_W+TBL_W+OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
  .map_en(map_en), .ready(ready), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .phys(phys), .done(done), .fault(fault)
);

// File: tb/sim_pg_walker.sv
module sim_pg_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_lin = '0;
  logic [31:0] root_base = '0;
  logic        map_en = 1'b0;
  logic        ready;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic [31:0] mem_data = '0;
  logic        mem_ack = 1'b0;
  logic [31:0] phys;
  logic        done;
  logic        fault;

  always #10 clk = ~clk;

  pg_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
    .root_base(root_base), .map_en(map_en), .ready(ready), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
    .phys(phys), .done(done), .fault(fault)
  );

  int n_chk = 0;
  int n_bad = 0;
  int lat_cfg = 0;
  int wcnt = 0;
  logic [31:0] held_addr = '0;
  int cyc = 0;

  logic [31:0] mem [logic [31:0]];
  logic [32:0] resq [$];
  string       tagq [$];
  logic [31:0] rdq  [$];

  task automatic chk(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdmem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic predict(input logic [31:0] lin, input bit en, input string tag);
    logic [31:0] da, ta, de, te;
    if (!en) begin
      resq.push_back({1'b0, lin});
    end else begin
      da = {root_base[31:12], 12'h000} + {20'h0, lin[31:22], 2'b00};
      rdq.push_back(da);
      de = rdmem(da);
      if (!de[0]) begin
        resq.push_back({1'b1, 32'h0});
      end else begin
        ta = {de[31:12], 12'h000} + {20'h0, lin[21:12], 2'b00};
        rdq.push_back(ta);
        te = rdmem(ta);
        if (!te[0]) resq.push_back({1'b1, 32'h0});
        else        resq.push_back({1'b0, te[31:12], lin[11:0]});
      end
    end
    tagq.push_back(tag);
  endtask

  task automatic issue(input logic [31:0] lin, input bit en, input int lat, input bit hold, input string tag);
    lat_cfg = lat;
    while (!ready) @(negedge clk);
    predict(lin, en, tag);
    req_valid = 1'b1;
    req_lin   = lin;
    map_en    = en;
    @(negedge clk);
    if (hold) begin
      req_lin = lin ^ 32'h0040_0000;
      map_en  = 1'b1;
      while (!ready) @(negedge clk);
    end
    req_valid = 1'b0;
    while (!(ready && resq.size() == 0)) @(negedge clk);
  endtask

  // memory model and read-address scoreboard (R3, R4, R8)
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (rst_n && mem_rd) begin
      if (wcnt == 0) held_addr = mem_addr;
      if (wcnt < lat_cfg) begin
        wcnt++;
      end else begin
        if (lat_cfg > 0)
          chk(mem_addr == held_addr, "R8 address held", {1'b0, mem_addr}, {1'b0, held_addr});
        if (rdq.size() == 0) begin
          chk(1'b0, "R2/R6 unexpected read", {1'b0, mem_addr}, 33'h0);
        end else begin
          logic [31:0] ea;
          ea = rdq.pop_front();
          chk(mem_addr == ea, "R3/R4 read address", {1'b0, mem_addr}, {1'b0, ea});
        end
        mem_data = rdmem(mem_addr);
        mem_ack  = 1'b1;
        wcnt     = 0;
      end
    end
  end

  // result monitor (R5, R6, R7, R9, R10, R11)
  always @(negedge clk) begin
    if (rst_n && (done || fault)) begin
      chk(!(done && fault), "R10 done and fault together", {fault, 31'h0, done}, 33'h1);
      if (resq.size() == 0) begin
        chk(1'b0, "R9 extra result", {fault, phys}, 33'h0);
      end else begin
        logic [32:0] e;
        string t;
        e = resq.pop_front();
        t = tagq.pop_front();
        chk({fault, phys} == e, t, {fault, phys}, e);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "watchdog", 33'h0, 33'h1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    mem[32'h0001_0004] = 32'h0002_0067;
    mem[32'h0002_000C] = 32'h1234_5F01;
    mem[32'h0001_0008] = 32'h0003_0FFE;
    mem[32'h0002_0014] = 32'hABCD_E000;
    mem[32'h0001_0FFC] = 32'h0004_0001;
    mem[32'h0004_0FFC] = 32'hFEDC_B003;
    mem[32'h0005_0000] = 32'h0006_0001;
    mem[32'h0006_0000] = 32'h0007_0FFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready after reset", {32'h0, ready}, 33'h1);
    chk(done == 1'b0, "R1 done after reset", {32'h0, done}, 33'h0);
    chk(fault == 1'b0, "R1 fault after reset", {32'h0, fault}, 33'h0);
    chk(mem_rd == 1'b0, "R1 mem_rd after reset", {32'h0, mem_rd}, 33'h0);

    root_base = 32'h0001_0000;
    issue(32'hDEAD_BEEF, 1'b0, 0, 1'b0, "R2 bypass");
    issue(32'h0040_3ABC, 1'b1, 0, 1'b0, "R5 walk zero wait, R11 flags");
    issue(32'h0040_3ABC, 1'b1, 3, 1'b0, "R8 walk with wait states");
    issue(32'h0080_0123, 1'b1, 1, 1'b0, "R6 directory not present");
    issue(32'h0040_5000, 1'b1, 0, 1'b0, "R7 table not present");
    issue(32'hFFFF_FFFF, 1'b1, 1, 1'b0, "R3 R4 top indices");
    root_base = 32'h0005_0123;
    issue(32'h0000_0010, 1'b1, 2, 1'b0, "R11 root and entry flag bits");
    root_base = 32'h0001_0000;
    issue(32'h0040_3ABC, 1'b1, 2, 1'b1, "R9 held request during walk");
    issue(32'h1357_9BDF, 1'b0, 0, 1'b1, "R9 held request during bypass");
    repeat (5) @(negedge clk);
    chk(resq.size() == 0 && rdq.size() == 0, "R10 one result per request",
        {1'b0, 16'(resq.size()), 16'(rdq.size())}, 33'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule